// File: doc/BRIEF.md
# NAND Flash Cycle Sequencer

This block turns a queue of 32-bit command words into cycles on a raw NAND flash bus. Software, or a DMA front end, pushes words into an eight-entry queue. The sequencer pops one word at a time and runs one of four cycle kinds: a command latch, an address latch, a burst of data writes or a burst of data reads. It drives the chip enable, the two latch enables, the write and read strobes and an 8-bit I/O bus, and it watches the ready/busy line of the flash device.

Each word carries the cycle kind, a byte value or a byte count, and three flags. The flags ask the sequencer to wait for the device to be ready, to close the operation by releasing chip enable, and to raise an interrupt when the word finishes. Write payload comes in through a valid/ready byte stream. Read payload leaves as a one-cycle valid pulse with its byte. A sticky done flag records every word that finishes. A sticky error flag records a word with a forbidden flag mix, and while the error flag is set it hides the done flag and the interrupt.

Top module: `nand_seq`

## Requirements
- R1: Bits 17:16 of a command word select the cycle kind: 0 is an address latch, 1 is a command latch, 2 is a data write and 3 is a data read. A command-latch word produces one write-strobe pulse with CLE high, ALE low and bits 7:0 on the I/O bus. An address-latch word produces the same pulse with ALE high and CLE low. CLE and ALE are never high together.
- R2: A data-write word takes bits 11:0 as N and produces N+1 write-strobe pulses with CLE and ALE low. Each pulse drives the next byte accepted from the transmit stream.
- R3: A data-read word takes bits 11:0 as N and produces N+1 read-strobe pulses. On each pulse the I/O input is sampled at the rising edge of the read strobe and sent out as one rx_valid pulse. The write and read strobes are never low together.
- R4: When bit 19 (wait-for-ready) is set, the word does not complete while nand_rb_n is low after its bus cycle. It completes once nand_rb_n is high.
- R5: Chip enable goes low when a word starts and stays low across later words. It goes high only after a word with bit 18 (last cycle) completes. It is low whenever either strobe is low.
- R6: Each completed word sets stat_done. The flag stays set until status_clr[0] is pulsed.
- R7: irq is set only by a completed word that has bit 13 set. Pulsing status_clr[0] clears it.
- R8: An address-latch word with bit 19 set is an error. It produces no strobe and sets stat_err, and chip enable goes high. While stat_err is set, stat_done and irq read 0. The hidden done state returns when status_clr[1] clears the error.
- R9: The queue holds 8 words and reports cmd_full and cmd_empty. A push while the queue is full is dropped. Words run in the order they were pushed.
- R10: Every strobe pulse stays low for exactly PULSE_LO clock cycles. After a pulse the strobe stays high for at least PULSE_HI cycles before the next one.
- R11: After reset, chip enable and both strobes are high, the queue is empty and not full, and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_push | input | 1 | Push cmd_word into the queue |
| cmd_word | input | 32 | Command word |
| cmd_full | output | 1 | Queue holds 8 words |
| cmd_empty | output | 1 | Queue holds no word |
| tx_data | input | 8 | Write payload byte |
| tx_valid | input | 1 | Write payload byte is present |
| tx_ready | output | 1 | Write payload byte is taken on this clock |
| rx_data | output | 8 | Read payload byte |
| rx_valid | output | 1 | rx_data is valid for one cycle |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus output value |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus input value |
| nand_rb_n | input | 1 | Device ready (1) or busy (0) |
| status_clr | input | 2 | Bit 0 clears done and irq, bit 1 clears error |
| stat_done | output | 1 | A word has completed (hidden while in error) |
| stat_err | output | 1 | A forbidden word was seen |
| irq | output | 1 | Completion interrupt (hidden while in error) |

## Verification
The bench runs each of the four cycle kinds on its own. The bus monitor tells command latches, address latches and write data apart by the latch enables it sees on each rising write strobe, and it measures the low time of every strobe. Multi-byte writes and reads use distinct byte sequences, so a dropped, repeated or reordered byte shows up as a mismatch. The bench holds ready/busy low across a wait-for-ready word to separate a completion that is held back from one that is not. It fills the queue behind a stalled word to show the drop on overflow and the order in which words run. A forbidden word sent while done is pending shows that the error masks the done flag without losing it.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  localparam int LEN_W = 12;

  typedef enum logic [1:0] {
    CYC_ADDR = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_WR   = 2'd2,
    CYC_RD   = 2'd3
  } cyc_e;

  // decoded queue entry: only the fields the engine uses
  typedef struct packed {
    cyc_e             cyc;
    logic             wfr;
    logic             last;
    logic             iwc;
    logic [LEN_W-1:0] arg;
  } ent_t;

  localparam int ENT_W = $bits(ent_t);

  // wait-for-ready on an address latch is a forbidden mix
  function automatic logic ent_bad(input ent_t e);
    return (e.cyc == CYC_ADDR) && e.wfr;
  endfunction

  function automatic logic ent_is_data(input ent_t e);
    return (e.cyc == CYC_WR) || (e.cyc == CYC_RD);
  endfunction

  // number of strobe pulses the entry produces
  function automatic int ent_pulses(input ent_t e);
    return ent_is_data(e) ? int'(e.arg) + 1 : 1;
  endfunction
endpackage

// File: rtl/nseq_fifo.sv
module nseq_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= ptr_next(wp);
      if (pop_ok)  rp <= ptr_next(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);

  // R9
  never_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/nseq_engine.sv
module nseq_engine
  import nseq_pkg::*;
#(
  parameter int PULSE_LO = 3,
  parameter int PULSE_HI = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       q_empty,
  input  ent_t       q_ent,
  output logic       q_pop,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       nand_ce_n,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic [7:0] nand_io_out,
  output logic       nand_io_oe,
  input  logic [7:0] nand_io_in,
  input  logic       nand_rb_n,
  output logic       evt_done,
  output logic       evt_err,
  output logic       evt_irq
);
  localparam int PMAX = (PULSE_LO > PULSE_HI) ? PULSE_LO : PULSE_HI;
  localparam int TW   = $clog2(PMAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_ARM, S_LO, S_HI, S_WAIT, S_DONE
  } st_e;

  st_e              st;
  ent_t             cur;
  logic [TW-1:0]    tmr;
  logic [LEN_W-1:0] remain;
  logic [7:0]       obyte;
  logic             ce_on;
  logic             in_cycle, strobe_lo, lo_end, hi_end;

  assign q_pop     = (st == S_IDLE) && !q_empty;
  assign in_cycle  = (st == S_ARM) || (st == S_LO) || (st == S_HI);
  assign strobe_lo = (st == S_LO);
  assign lo_end    = strobe_lo && (tmr == '0);
  assign hi_end    = (st == S_HI) && (tmr == '0);

  assign nand_ce_n   = !ce_on;
  assign nand_cle    = in_cycle && (cur.cyc == CYC_CMD);
  assign nand_ale    = in_cycle && (cur.cyc == CYC_ADDR);
  assign nand_we_n   = !(strobe_lo && (cur.cyc != CYC_RD));
  assign nand_re_n   = !(strobe_lo && (cur.cyc == CYC_RD));
  assign nand_io_oe  = in_cycle && (cur.cyc != CYC_RD);
  assign nand_io_out = obyte;
  assign tx_ready    = (st == S_ARM) && (cur.cyc == CYC_WR);

  assign evt_done = (st == S_DONE);
  assign evt_err  = (st == S_LOAD) && ent_bad(cur);
  assign evt_irq  = evt_done && cur.iwc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur      <= '0;
      tmr      <= '0;
      remain   <= '0;
      obyte    <= '0;
      ce_on    <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (q_pop) begin
          cur <= q_ent;
          st  <= S_LOAD;
        end
        S_LOAD: begin
          if (ent_bad(cur)) begin
            ce_on <= 1'b0;
            st    <= S_IDLE;
          end else begin
            ce_on  <= 1'b1;
            remain <= cur.arg;
            obyte  <= cur.arg[7:0];
            st     <= S_ARM;
          end
        end
        S_ARM: begin
          if (cur.cyc != CYC_WR || tx_valid) begin
            if (cur.cyc == CYC_WR) obyte <= tx_data;
            tmr <= TW'(PULSE_LO - 1);
            st  <= S_LO;
          end
        end
        S_LO: begin
          if (lo_end) begin
            tmr <= TW'(PULSE_HI - 1);
            st  <= S_HI;
            if (cur.cyc == CYC_RD) begin
              rx_data  <= nand_io_in;
              rx_valid <= 1'b1;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_HI: begin
          if (hi_end) begin
            if (ent_is_data(cur) && remain != '0) begin
              remain <= remain - 1'b1;
              st     <= S_ARM;
            end else begin
              st <= cur.wfr ? S_WAIT : S_DONE;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_WAIT: if (nand_rb_n) st <= S_DONE;
        S_DONE: begin
          if (cur.last) ce_on <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R5
  ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !nand_rb_n) |=> !evt_done);

  // R8
  bad_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> (nand_we_n && nand_re_n && nand_ce_n));

  // R10
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_lo && tmr != '0) |=> $stable(nand_we_n) && $stable(nand_re_n));
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nseq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int PULSE_LO = 3,
  parameter int PULSE_HI = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_push,
  input  logic [31:0] cmd_word,
  output logic        cmd_full,
  output logic        cmd_empty,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb_n,
  input  logic [1:0]  status_clr,
  output logic        stat_done,
  output logic        stat_err,
  output logic        irq
);
  ent_t in_ent, q_ent;
  logic q_pop, q_empty;
  logic evt_done, evt_err, evt_irq;
  logic done_q, err_q, irq_q;
  logic unused_word_bits;

  // field positions of the command word
  assign in_ent.cyc  = cyc_e'(cmd_word[17:16]);
  assign in_ent.wfr  = cmd_word[19];
  assign in_ent.last = cmd_word[18];
  assign in_ent.iwc  = cmd_word[13];
  assign in_ent.arg  = cmd_word[LEN_W-1:0];
  assign unused_word_bits = ^{cmd_word[31:20], cmd_word[15:14], cmd_word[12]};

  nseq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(in_ent),
    .pop(q_pop), .dout(q_ent), .full(cmd_full), .empty(q_empty)
  );
  assign cmd_empty = q_empty;

  nseq_engine #(.PULSE_LO(PULSE_LO), .PULSE_HI(PULSE_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_ent(q_ent), .q_pop(q_pop),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n),
    .evt_done(evt_done), .evt_err(evt_err), .evt_irq(evt_irq)
  );

  // sticky status: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= evt_done | (done_q & ~status_clr[0]);
      irq_q  <= evt_irq  | (irq_q  & ~status_clr[0]);
      err_q  <= evt_err  | (err_q  & ~status_clr[1]);
    end
  end

  assign stat_done = done_q & ~err_q;
  assign irq       = irq_q & ~err_q;
  assign stat_err  = err_q;

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !status_clr[0]) |=> done_q);

  // R7
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> done_q);
endmodule

// File: tb/nand_seq_test.sv
module nand_seq_test;
  localparam int CLK_P = 10;
  localparam int PLO   = 3;
  localparam int PHI   = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_push = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        cmd_full, cmd_empty;
  logic [7:0]  tx_data;
  logic        tx_valid = 1'b1;
  logic        tx_ready;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out, nand_io_in;
  logic        nand_rb_n = 1'b1;
  logic [1:0]  status_clr = '0;
  logic        stat_done, stat_err, irq;

  nand_seq #(.DEPTH(8), .PULSE_LO(PLO), .PULSE_HI(PHI)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_word(cmd_word),
    .cmd_full(cmd_full), .cmd_empty(cmd_empty),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n),
    .status_clr(status_clr), .stat_done(stat_done), .stat_err(stat_err), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard queues: bus events {kind,byte} (0 addr, 1 cmd, 2 write data), read bytes
  logic [9:0] ev_q[$];
  logic [7:0] rx_q[$];
  logic [7:0] tx_exp = 8'h10;
  logic [7:0] rd_exp = 8'h41;

  // transmit source: a counting byte stream
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_data <= 8'h10;
    else if (tx_ready && tx_valid) tx_data <= tx_data + 8'h01;

  // flash read model: next byte after each rising read strobe
  logic re_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      nand_io_in <= 8'h41;
      re_prev    <= 1'b1;
    end else begin
      re_prev <= nand_re_n;
      if (!re_prev && nand_re_n) nand_io_in <= nand_io_in + 8'h07;
    end

  // monitor, sampling at the falling clock edge
  logic we_s = 1'b1, re_s = 1'b1;
  int   we_lo = 0, re_lo = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n) we_lo++;
      if (!nand_re_n) re_lo++;
      if (!we_s && nand_we_n) begin
        logic [1:0] kind;
        logic [9:0] exp;
        kind = nand_cle ? 2'd1 : (nand_ale ? 2'd0 : 2'd2);
        chk(we_lo == PLO, "R10 write strobe low width", we_lo, PLO);
        if (ev_q.size() == 0) chk(1'b0, "R1/R2 unexpected bus event", {kind, nand_io_out}, 0);
        else begin
          exp = ev_q.pop_front();
          chk({kind, nand_io_out} == exp, "R1/R2 bus event", {kind, nand_io_out}, exp);
        end
        we_lo = 0;
      end
      if (!re_s && nand_re_n) begin
        chk(re_lo == PLO, "R10 read strobe low width", re_lo, PLO);
        re_lo = 0;
      end
      if (rx_valid) begin
        if (rx_q.size() == 0) chk(1'b0, "R3 unexpected rx byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = rx_q.pop_front();
          chk(rx_data == e, "R3 read byte", rx_data, e);
        end
      end
      we_s = nand_we_n;
      re_s = nand_re_n;
    end
  end

  function automatic logic [31:0] mk(input int cyc, input bit wfr, input bit last,
                                     input bit iwc, input int arg);
    return (32'(cyc) << 16) | (32'(wfr) << 19) | (32'(last) << 18) |
           (32'(iwc) << 13) | (32'(arg) & 32'hFFF);
  endfunction

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    cmd_push = 1'b1;
    cmd_word = w;
    @(negedge clk);
    cmd_push = 1'b0;
  endtask

  task automatic clr(input logic [1:0] m);
    @(negedge clk);
    status_clr = m;
    @(negedge clk);
    status_clr = '0;
  endtask

  task automatic wait_done(input string req);
    for (int i = 0; i < 3000 && !stat_done; i++) @(negedge clk);
    chk(stat_done, req, stat_done, 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R11 reset state
    chk(nand_ce_n && nand_we_n && nand_re_n, "R11 strobes/ce idle", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    chk(cmd_empty && !cmd_full, "R11 queue empty", {cmd_full, cmd_empty}, 2'b01);
    chk(!stat_done && !stat_err && !irq, "R11 status clear", {stat_done, stat_err, irq}, 0);
    rst_n = 1'b1;
    idle(2);

    // R1 command latch with wait-for-ready, not last
    ev_q.push_back({2'd1, 8'h90});
    push(mk(1, 1, 0, 0, 8'h90));
    wait_done("R6 done after command");
    chk(!nand_ce_n, "R5 ce held after non-last", nand_ce_n, 0);
    chk(!irq, "R7 no irq without flag", irq, 0);
    clr(2'b01);
    chk(!stat_done, "R6 done cleared", stat_done, 0);

    // R1 address latch, last, interrupt
    ev_q.push_back({2'd0, 8'h3C});
    push(mk(0, 0, 1, 1, 8'h3C));
    wait_done("R6 done after address");
    idle(1);
    chk(nand_ce_n, "R5 ce released after last", nand_ce_n, 1);
    chk(irq, "R7 irq with flag", irq, 1);
    clr(2'b01);
    chk(!irq, "R7 irq cleared", irq, 0);

    // R2 four-byte write
    for (int i = 0; i < 4; i++) begin
      ev_q.push_back({2'd2, tx_exp});
      tx_exp = tx_exp + 8'h01;
    end
    push(mk(2, 0, 1, 0, 3));
    wait_done("R2 write complete");
    chk(ev_q.size() == 0, "R2 all write bytes seen", ev_q.size(), 0);
    clr(2'b01);

    // R3 three-byte read
    for (int i = 0; i < 3; i++) begin
      rx_q.push_back(rd_exp);
      rd_exp = rd_exp + 8'h07;
    end
    push(mk(3, 0, 1, 0, 2));
    wait_done("R3 read complete");
    idle(2);
    chk(rx_q.size() == 0, "R3 all read bytes seen", rx_q.size(), 0);
    clr(2'b01);

    // R4 wait-for-ready held while busy
    nand_rb_n = 1'b0;
    ev_q.push_back({2'd1, 8'h70});
    push(mk(1, 1, 1, 0, 8'h70));
    idle(40);
    chk(ev_q.size() == 0, "R4 cycle ran", ev_q.size(), 0);
    chk(!stat_done, "R4 done withheld while busy", stat_done, 0);
    nand_rb_n = 1'b1;
    idle(4);
    chk(stat_done, "R4 done after ready", stat_done, 1);
    clr(2'b01);

    // R8 forbidden word masks a pending done
    ev_q.push_back({2'd1, 8'hFF});
    push(mk(1, 0, 1, 0, 8'hFF));
    wait_done("R8 setup done");
    push(mk(0, 1, 1, 1, 8'h55));
    idle(10);
    chk(stat_err, "R8 error flag set", stat_err, 1);
    chk(!stat_done && !irq, "R8 done/irq masked", {stat_done, irq}, 0);
    chk(nand_ce_n, "R8 ce high after error", nand_ce_n, 1);
    clr(2'b10);
    chk(!stat_err && stat_done, "R8 done back after clear", {stat_err, stat_done}, 2'b01);
    clr(2'b01);

    // R9 fill the queue behind a stalled word, then overflow
    nand_rb_n = 1'b0;
    ev_q.push_back({2'd1, 8'h60});
    push(mk(1, 1, 1, 0, 8'h60));
    idle(30);
    for (int i = 0; i < 8; i++) begin
      ev_q.push_back({2'd0, 8'hB0 + 8'(i)});
      push(mk(0, 0, (i == 7), 0, 8'hB0 + i));
    end
    chk(cmd_full, "R9 full after 8", cmd_full, 1);
    push(mk(0, 0, 1, 0, 8'hEE));
    chk(cmd_full, "R9 still full after drop", cmd_full, 1);
    nand_rb_n = 1'b1;
    idle(300);
    chk(cmd_empty, "R9 empty after drain", cmd_empty, 1);
    chk(ev_q.size() == 0, "R9 all queued words ran in order", ev_q.size(), 0);
    chk(nand_ce_n, "R5 ce released at end", nand_ce_n, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule